// File: doc/BRIEF.md
# Software-Generated Interrupt Acceptance Filter

This block sits in front of the pending bitmap of one CPU's private interrupts. IDs 0 to 15 are software-generated: a request names an ID, a requested group and whether it comes from the non-secure world. The block checks the request against the configured group of that ID, a two-bit non-secure permission field per ID and a global security-disable input. Only a request that passes all checks sets its pending bit. IDs 16 to 31 are private line inputs. Each line's level is stored every cycle. A line that is configured edge-triggered latches its pending bit on a rising level.

The edge/level selection of the line inputs is written as one 32-bit word. The odd bit 2n+1 of the word selects edge mode for line n. In a non-secure write with security enabled, only the lines configured as group 1 can be changed. Whenever a request is accepted, a pending bit changes, or a stored line level changes, the block raises a one-cycle update strobe so that the downstream arbitration can run again.

The request interface is a valid/ready stream. `sgi_ready` is high in every cycle out of reset, so the block never applies back-pressure. A request is consumed in every cycle in which `sgi_valid` is high, whether it is accepted or dropped.

Top module: `sgi_accept_filter`

## Requirements
- R1: After reset, `pend`, `trig_edge` and `line_lvl` are all zero, `upd` is low, and `sgi_ready` is high.
- R2: A request with `sgi_grp1`=1 that targets an ID whose `grp_cfg` bit is 0 (group 0) is handled as a group-0 request.
- R3: After the R2 adjustment, a request whose group differs from `grp_cfg[id]` is dropped. In particular, a group-0 request to a group-1 ID is dropped.
- R4: When `sgi_ns`=1 and `sec_off`=0, the permission p is `ns_perm[2*id+1:2*id]`. A group-0 ID needs p>=1 and a group-1 ID needs p>=2, or the request is dropped. When `sgi_ns`=0 or `sec_off`=1, the permission field is ignored.
- R5: An accepted request sets `pend[id]` at the next clock edge. A dropped request leaves `pend` unchanged. Pending bits are never cleared except by reset.
- R6: `line_lvl[n]` takes the value of `line_in[n]` at each clock edge. A 0-to-1 change on `line_in[n]` while `trig_edge[n]`=1 sets `pend[16+n]` at that edge. A line with `trig_edge[n]`=0 never sets its pending bit.
- R7: When `trig_we`=1, `trig_edge[n]` is loaded from `trig_wdata[2n+1]`. The even bits of the word are ignored.
- R8: When a write has `trig_ns`=1 and `sec_off`=0, only `trig_edge[n]` with `grp_cfg[16+n]`=1 may change. The other bits keep their values.
- R9: `upd` is high for exactly one cycle after any edge at which a request was accepted, a pending bit changed, or a stored line level changed. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sgi_valid | input | 1 | Request present |
| sgi_ready | output | 1 | Always high out of reset; no back-pressure |
| sgi_id | input | 4 | Target software interrupt ID |
| sgi_grp1 | input | 1 | Requested group (1 = group 1) |
| sgi_ns | input | 1 | Request comes from the non-secure world |
| sec_off | input | 1 | Security disabled globally |
| grp_cfg | input | 32 | Configured group per ID (1 = group 1) |
| ns_perm | input | 32 | Two-bit non-secure permission per software ID |
| line_in | input | 16 | Private line inputs for IDs 16..31 |
| trig_we | input | 1 | Write strobe for the trigger-mode word |
| trig_ns | input | 1 | The trigger-mode write is non-secure |
| trig_wdata | input | 32 | Trigger-mode word; bit 2n+1 selects edge for line n |
| pend | output | 32 | Pending bitmap for IDs 0..31 |
| trig_edge | output | 16 | Edge (1) or level (0) mode per line |
| line_lvl | output | 16 | Stored line levels |
| upd | output | 1 | One-cycle re-evaluation strobe |

## Verification
An error in the acceptance decision shows up on `pend` and `upd` one edge after the request. A wrongly indexed permission slice or a missing group downgrade gives a wrong bit in a sweep that covers every combination of group, world, security and permission. A stale stored line level gives either a missing or an extra pending bit on the next rising line. It also moves the `upd` strobe by one cycle. A wrong write mask is visible on `trig_edge` right after the write.

// File: rtl/sgi_filter_pkg.sv
package sgi_filter_pkg;
  localparam int unsigned PERM_W = 2;
  typedef logic [PERM_W-1:0] perm_t;
  localparam perm_t PERM_G0_MIN = 2'd1;
  localparam perm_t PERM_G1_MIN = 2'd2;
endpackage

// File: rtl/sgi_gate.sv
module sgi_gate
  import sgi_filter_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned ID_W = $clog2(NUM_SGI)
) (
  input  logic                      req_valid,
  input  logic [ID_W-1:0]           req_id,
  input  logic                      req_grp1,
  input  logic                      req_ns,
  input  logic                      sec_off,
  input  logic [NUM_SGI-1:0]        grp_bits,
  input  logic [PERM_W*NUM_SGI-1:0] perm_bits,
  output logic                      accept
);
  logic  tgt_grp1;
  logic  eff_grp1;
  perm_t perm;
  logic  perm_ok;

  always_comb begin
    tgt_grp1 = grp_bits[req_id];
    // a group-1 request aimed at a group-0 ID is downgraded
    eff_grp1 = req_grp1 & tgt_grp1;
    perm     = perm_bits[PERM_W*req_id +: PERM_W];
    if (req_ns && !sec_off)
      perm_ok = tgt_grp1 ? (perm >= PERM_G1_MIN) : (perm >= PERM_G0_MIN);
    else
      perm_ok = 1'b1;
    accept = req_valid && (eff_grp1 == tgt_grp1) && perm_ok;
  end
endmodule

// File: rtl/line_track.sv
module line_track #(
  parameter int unsigned NUM_LINE = 16,
  localparam int unsigned WORD_W = 2 * NUM_LINE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LINE-1:0] line_in,
  input  logic                cfg_we,
  input  logic [WORD_W-1:0]   cfg_word,
  input  logic [NUM_LINE-1:0] cfg_mask,
  output logic [NUM_LINE-1:0] edge_mode,
  output logic [NUM_LINE-1:0] lvl_q,
  output logic [NUM_LINE-1:0] rise_set,
  output logic                lvl_chg
);
  logic [NUM_LINE-1:0] sel_bits;

  for (genvar n = 0; n < NUM_LINE; n++) begin : g_line
    assign sel_bits[n] = cfg_word[2*n+1];
    assign rise_set[n] = line_in[n] & ~lvl_q[n] & edge_mode[n];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        edge_mode[n] <= 1'b0;
        lvl_q[n]     <= 1'b0;
      end else begin
        if (cfg_we && cfg_mask[n]) edge_mode[n] <= sel_bits[n];
        lvl_q[n] <= line_in[n];
      end
    end
  end

  assign lvl_chg = |(line_in ^ lvl_q);

  assert_trig_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (((edge_mode ^ $past(edge_mode)) & ~$past(cfg_mask)) == '0));

  assert_lvl_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_q == $past(line_in)));
endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
  import sgi_filter_pkg::*;
#(
  parameter int unsigned NUM_SGI  = 16,
  parameter int unsigned NUM_LINE = 16,
  localparam int unsigned ID_W   = $clog2(NUM_SGI),
  localparam int unsigned NUM_ID = NUM_SGI + NUM_LINE,
  localparam int unsigned WORD_W = 2 * NUM_LINE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sgi_valid,
  output logic                      sgi_ready,
  input  logic [ID_W-1:0]           sgi_id,
  input  logic                      sgi_grp1,
  input  logic                      sgi_ns,
  input  logic                      sec_off,
  input  logic [NUM_ID-1:0]         grp_cfg,
  input  logic [PERM_W*NUM_SGI-1:0] ns_perm,
  input  logic [NUM_LINE-1:0]       line_in,
  input  logic                      trig_we,
  input  logic                      trig_ns,
  input  logic [WORD_W-1:0]         trig_wdata,
  output logic [NUM_ID-1:0]         pend,
  output logic [NUM_LINE-1:0]       trig_edge,
  output logic [NUM_LINE-1:0]       line_lvl,
  output logic                      upd
);
  logic                accept;
  logic [NUM_LINE-1:0] wmask;
  logic [NUM_LINE-1:0] rise_set;
  logic                lvl_chg;
  logic [NUM_SGI-1:0]  sgi_set;
  logic [NUM_ID-1:0]   pend_nxt;

  assign sgi_ready = 1'b1;

  sgi_gate #(.NUM_SGI(NUM_SGI)) u_gate (
    .req_valid (sgi_valid),
    .req_id    (sgi_id),
    .req_grp1  (sgi_grp1),
    .req_ns    (sgi_ns),
    .sec_off   (sec_off),
    .grp_bits  (grp_cfg[NUM_SGI-1:0]),
    .perm_bits (ns_perm),
    .accept    (accept)
  );

  // non-secure writes with security on may touch group-1 lines only
  assign wmask = (trig_ns && !sec_off) ? grp_cfg[NUM_ID-1:NUM_SGI] : '1;

  line_track #(.NUM_LINE(NUM_LINE)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .cfg_we    (trig_we),
    .cfg_word  (trig_wdata),
    .cfg_mask  (wmask),
    .edge_mode (trig_edge),
    .lvl_q     (line_lvl),
    .rise_set  (rise_set),
    .lvl_chg   (lvl_chg)
  );

  always_comb begin
    sgi_set = '0;
    if (accept) sgi_set[sgi_id] = 1'b1;
    pend_nxt = pend | {rise_set, sgi_set};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      upd  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      upd  <= accept | (pend_nxt != pend) | lvl_chg;
    end
  end

  assert_accept_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pend[$past(sgi_id)]);

  assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~pend) == '0));

  assert_drop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (pend[NUM_SGI-1:0] == $past(pend[NUM_SGI-1:0])));

  assert_level_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend[NUM_ID-1:NUM_SGI] & ~$past(pend[NUM_ID-1:NUM_SGI])
               & ~$past(trig_edge)) == '0));

  assert_upd_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> upd);
endmodule

// File: tb/sgi_accept_filter_tb.sv
module sgi_accept_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sgi_valid, sgi_ready, sgi_grp1, sgi_ns, sec_off;
  logic [3:0]  sgi_id;
  logic [31:0] grp_cfg, ns_perm, trig_wdata, pend;
  logic [15:0] line_in, trig_edge, line_lvl;
  logic        trig_we, trig_ns, upd;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sgi_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n), .sgi_valid(sgi_valid), .sgi_ready(sgi_ready),
    .sgi_id(sgi_id), .sgi_grp1(sgi_grp1), .sgi_ns(sgi_ns), .sec_off(sec_off),
    .grp_cfg(grp_cfg), .ns_perm(ns_perm), .line_in(line_in),
    .trig_we(trig_we), .trig_ns(trig_ns), .trig_wdata(trig_wdata),
    .pend(pend), .trig_edge(trig_edge), .line_lvl(line_lvl), .upd(upd)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sgi_valid = 0; sgi_grp1 = 0; sgi_ns = 0; sgi_id = 0;
    sec_off = 0; grp_cfg = 0; ns_perm = 0; line_in = 0;
    trig_we = 0; trig_ns = 0; trig_wdata = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] spread(input logic [15:0] m);
    logic [31:0] w = 32'h5555_5555;  // even bits set, must be ignored
    for (int n = 0; n < 16; n++) w[2*n+1] = m[n];
    return w;
  endfunction

  task automatic trig_write(input logic [31:0] w, input bit ns, input bit off);
    trig_wdata = w; trig_ns = ns; sec_off = off; trig_we = 1'b1;
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state
    check(pend == 0, "R1 pend", pend, 0);
    check(trig_edge == 0 && line_lvl == 0, "R1 trig/lvl", {trig_edge, line_lvl}, 0);
    check(!upd && sgi_ready, "R1 upd/ready", {upd, sgi_ready}, 32'b01);

    // R2 R3 R4 R5 R9: sweep over group, world, security and permission
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 64; c++) begin
        logic [3:0] id;
        bit rq, g, ns, ds, ok;
        logic [1:0] p;
        string tag;
        id = 4'(k * 5);
        rq = c[0]; g = c[1]; ns = c[2]; ds = c[3]; p = c[5:4];
        do_reset();
        grp_cfg = ~32'h0;
        grp_cfg[id] = g;
        grp_cfg[(id + 1) % 16] = ~g;
        ns_perm = {16{~p}};
        ns_perm[2*id +: 2] = p;
        sec_off = ds;
        ok = ((rq & g) == g);
        tag = (rq && !g) ? "R2" : "R3";
        if (ok && ns && !ds) begin
          ok = g ? (p >= 2) : (p >= 1);
          tag = "R4";
        end
        sgi_id = id; sgi_grp1 = rq; sgi_ns = ns; sgi_valid = 1'b1;
        @(negedge clk);
        sgi_valid = 1'b0;
        check(pend == (ok ? (32'd1 << id) : 32'd0), {tag, " R5 pend"}, pend,
              ok ? (32'd1 << id) : 32'd0);
        check(upd == ok, "R9 upd after request", upd, ok);
        @(negedge clk);
        check(!upd, "R9 upd one cycle", upd, 0);
      end
    end

    // R7: trigger word loading, even bits ignored
    do_reset();
    trig_write(spread(16'h5555), 0, 0);
    check(trig_edge == 16'h5555, "R7 edge load", trig_edge, 16'h5555);
    // R8: non-secure write with security on touches group-1 lines only
    grp_cfg = 32'h00FF_0000;
    trig_write(spread(16'hFFFF) & ~32'h5555_5555, 1, 0);
    check(trig_edge == 16'h55FF, "R8 ns masked", trig_edge, 16'h55FF);
    trig_write(spread(16'h0000), 1, 0);
    check(trig_edge == 16'h5500, "R8 ns clear masked", trig_edge, 16'h5500);
    trig_write(spread(16'h0F0F), 1, 1);
    check(trig_edge == 16'h0F0F, "R8 ns with security off", trig_edge, 16'h0F0F);
    trig_write(spread(16'hA5C3), 0, 0);
    check(trig_edge == 16'hA5C3, "R7 secure full write", trig_edge, 16'hA5C3);
    sec_off = 0;
    check(!upd && pend == 0, "R9 no strobe on config", {upd, pend[30:0]}, 0);

    // R6 R9: rising lines latch only in edge mode
    line_in = 16'hFFFF;
    @(negedge clk);
    check(pend == {16'hA5C3, 16'h0}, "R6 rising edge lines", pend, {16'hA5C3, 16'h0});
    check(line_lvl == 16'hFFFF, "R6 level stored", line_lvl, 16'hFFFF);
    check(upd, "R9 upd on rise", upd, 1);
    @(negedge clk);
    check(!upd, "R9 upd steady level", upd, 0);
    line_in = 16'h0000;
    @(negedge clk);
    check(pend == {16'hA5C3, 16'h0}, "R6 fall keeps pend", pend, {16'hA5C3, 16'h0});
    check(upd && line_lvl == 0, "R9 upd on level change", {upd, line_lvl}, 32'h1_0000);

    // R6: each level-mode line alone never latches
    do_reset();
    for (int n = 0; n < 16; n++) begin
      line_in = 16'd1 << n;
      @(negedge clk);
      check(pend == 0 && line_lvl == line_in, "R6 level line no latch",
            {pend[15:0], line_lvl}, {16'h0, line_in});
    end
    finish_run();
  end
endmodule